// File: doc/BRIEF.md
# Dependence-Aware Issue Delay Predictor

This block works beside the register renamer. Each cycle it takes a group of four renamed instructions and predicts how many cycles each one must wait before it can issue. It keeps a small table with one entry per physical register. Each entry holds the number of cycles until that register's value is expected to be available. All entries count down by one per cycle and stop at zero, so every value in the table is measured from the current cycle.

For each instruction, the predicted wait is the larger of the two source-register times. That wait plus the instruction's execution latency gives the time at which its destination becomes available. A later member of the same group may read a register that an earlier member writes. In that case a mux chain hands it the earlier member's freshly computed time instead of the old table value. The table is written with the group's destination times at the end of the cycle. When several members write the same register, the youngest member's value is kept. A time that does not fit in the counter is clamped to the maximum and raises a reschedule flag for that instruction. Results appear one cycle after the group is presented.

Top module: `prsched_top`

## Requirements
- R1: During and after reset, all outputs are zero and every table entry is zero, so an instruction whose sources were never written gets a wait of 0.
- R2: The wait reported for a valid slot is the maximum of the table times of its two sources. It appears on `waitLat` with `outValid` set in the cycle after the group is presented.
- R3: A valid slot with `dstEn` set writes its destination's time as wait plus `opLat`. An instruction in a group presented k cycles later reads that time minus k, floored at zero.
- R4: Every table entry that is not written in a cycle decreases by one in that cycle and stops at zero.
- R5: A slot whose source matches the destination of an earlier valid, writing slot in the same group uses that slot's computed destination time rather than the table value.
- R6: When several earlier slots in the group write the matching register, the nearest earlier slot (highest index below the reader) supplies the time.
- R7: When several slots in a group write the same register, the table keeps the time of the highest-index writer.
- R8: When wait plus `opLat` exceeds 2^LAT_W-1, the destination time is clamped to 2^LAT_W-1 and `resched` is raised for that slot. `resched` is never high for a slot whose `outValid` is low.
- R9: With `grpValid` low, or for a slot whose `instValid` is low, no table entry is written, and `outValid` is low in the following cycle.
- R10: `outValid` is the per-slot `instValid` mask of the previous cycle's group. A slot with `outValid` low shows `waitLat` and `resched` as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| grpValid | input | 1 | A rename group is presented this cycle |
| instValid | input | 4 | Per-slot instruction present (bit i = slot i, slot 0 oldest) |
| dstEn | input | 4 | Per-slot destination register written |
| srcA | input | 4x5 | First source physical register per slot |
| srcB | input | 4x5 | Second source physical register per slot |
| dst | input | 4x5 | Destination physical register per slot |
| opLat | input | 4x3 | Execution latency per slot |
| outValid | output | 4 | Per-slot result valid, one cycle after the group |
| waitLat | output | 4x4 | Predicted cycles until issue per slot |
| resched | output | 4 | Destination time saturated for this slot |

## Verification
The in-group forwarding path and the end-of-cycle table update happen in the same cycle. The table write must also collide with the countdown of every other entry. To provoke this, groups are sent back to back: one group's consumers read registers that earlier slots in the same group are producing. The next group reads the same registers again, and some groups write one register twice. A scoreboard model computes the forwarded times, the youngest-writer result and the countdown from the requirements. It compares each slot's wait and reschedule flag one cycle later. Ghost writes are also checked: these are dropped groups and invalid slots that carry destination enables. A later read must show that they left the table untouched.

// File: rtl/prsched_pkg.sv
package prsched_pkg;
  localparam int unsigned GRP_N = 4;

  typedef struct packed {
    logic             capture;
    logic [GRP_N-1:0] live;
    logic [GRP_N-1:0] wrEn;
  } strobe_t;
endpackage

// File: rtl/prsched_ctrl.sv
module prsched_ctrl
  import prsched_pkg::*;
(
  input  logic             grpValid,
  input  logic [GRP_N-1:0] instValid,
  input  logic [GRP_N-1:0] dstEn,
  output strobe_t          stb
);
  assign stb.capture = grpValid;

  for (genvar s = 0; s < GRP_N; s++) begin : g_slot
    assign stb.live[s] = grpValid & instValid[s];
    assign stb.wrEn[s] = grpValid & instValid[s] & dstEn[s];
  end
endmodule

// File: rtl/prsched_dpath.sv
module prsched_dpath
  import prsched_pkg::*;
#(
  parameter int unsigned NUM_PREGS = 32,
  parameter int unsigned LAT_W     = 4,
  parameter int unsigned OPL_W     = 3,
  parameter int unsigned PR_W      = $clog2(NUM_PREGS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     stb,
  input  logic [GRP_N-1:0][PR_W-1:0]  srcA,
  input  logic [GRP_N-1:0][PR_W-1:0]  srcB,
  input  logic [GRP_N-1:0][PR_W-1:0]  dst,
  input  logic [GRP_N-1:0][OPL_W-1:0] opLat,
  output logic [GRP_N-1:0]            outValid,
  output logic [GRP_N-1:0][LAT_W-1:0] waitLat,
  output logic [GRP_N-1:0]            resched
);
  localparam int unsigned SUM_W = LAT_W + 1;
  localparam logic [LAT_W-1:0] MAXV = {LAT_W{1'b1}};

  logic [LAT_W-1:0] tbl   [NUM_PREGS];
  logic [LAT_W-1:0] issT  [GRP_N];
  logic [LAT_W-1:0] doneT [GRP_N];
  logic [GRP_N-1:0] ovf;

  function automatic logic [LAT_W-1:0] satDec(input logic [LAT_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  // issue time per slot, with the bypass mux chain over earlier slots
  always_comb begin
    logic [LAT_W-1:0] tA, tB;
    logic [SUM_W-1:0] sum;
    for (int i = 0; i < GRP_N; i++) begin
      tA = tbl[srcA[i]];
      tB = tbl[srcB[i]];
      for (int j = 0; j < i; j++) begin
        if (stb.wrEn[j] && dst[j] == srcA[i]) tA = doneT[j];
        if (stb.wrEn[j] && dst[j] == srcB[i]) tB = doneT[j];
      end
      issT[i]  = (tA > tB) ? tA : tB;
      sum      = {1'b0, issT[i]} + SUM_W'(opLat[i]);
      ovf[i]   = sum > SUM_W'(MAXV);
      doneT[i] = ovf[i] ? MAXV : sum[LAT_W-1:0];
    end
  end

  // relative-time table: countdown everywhere, then group writes, youngest last
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_PREGS; k++) tbl[k] <= '0;
    end else begin
      for (int k = 0; k < NUM_PREGS; k++) tbl[k] <= satDec(tbl[k]);
      for (int j = 0; j < GRP_N; j++)
        if (stb.wrEn[j]) tbl[dst[j]] <= satDec(doneT[j]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= '0;
      waitLat  <= '0;
      resched  <= '0;
    end else if (stb.capture) begin
      outValid <= stb.live;
      for (int i = 0; i < GRP_N; i++) begin
        waitLat[i] <= stb.live[i] ? issT[i] : '0;
        resched[i] <= stb.live[i] & ovf[i];
      end
    end else begin
      outValid <= '0;
      waitLat  <= '0;
      resched  <= '0;
    end
  end
endmodule

// File: rtl/prsched_top.sv
module prsched_top
  import prsched_pkg::*;
#(
  parameter  int unsigned NUM_PREGS = 32,
  parameter  int unsigned LAT_W     = 4,
  parameter  int unsigned OPL_W     = 3,
  localparam int unsigned PR_W      = $clog2(NUM_PREGS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        grpValid,
  input  logic [GRP_N-1:0]            instValid,
  input  logic [GRP_N-1:0]            dstEn,
  input  logic [GRP_N-1:0][PR_W-1:0]  srcA,
  input  logic [GRP_N-1:0][PR_W-1:0]  srcB,
  input  logic [GRP_N-1:0][PR_W-1:0]  dst,
  input  logic [GRP_N-1:0][OPL_W-1:0] opLat,
  output logic [GRP_N-1:0]            outValid,
  output logic [GRP_N-1:0][LAT_W-1:0] waitLat,
  output logic [GRP_N-1:0]            resched
);
  strobe_t stb;

  prsched_ctrl u_ctrl (
    .grpValid (grpValid),
    .instValid(instValid),
    .dstEn    (dstEn),
    .stb      (stb)
  );

  prsched_dpath #(
    .NUM_PREGS(NUM_PREGS),
    .LAT_W    (LAT_W),
    .OPL_W    (OPL_W),
    .PR_W     (PR_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .srcA    (srcA),
    .srcB    (srcB),
    .dst     (dst),
    .opLat   (opLat),
    .outValid(outValid),
    .waitLat (waitLat),
    .resched (resched)
  );
endmodule

// File: rtl/prsched_chk.sv
module prsched_chk
  import prsched_pkg::*;
#(
  parameter  int unsigned NUM_PREGS = 32,
  parameter  int unsigned LAT_W     = 4,
  parameter  int unsigned OPL_W     = 3,
  localparam int unsigned PR_W      = $clog2(NUM_PREGS)
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        grpValid,
  input logic [GRP_N-1:0]            instValid,
  input logic [GRP_N-1:0]            dstEn,
  input logic [GRP_N-1:0][PR_W-1:0]  srcA,
  input logic [GRP_N-1:0][PR_W-1:0]  srcB,
  input logic [GRP_N-1:0][PR_W-1:0]  dst,
  input logic [GRP_N-1:0][OPL_W-1:0] opLat,
  input logic [GRP_N-1:0]            outValid,
  input logic [GRP_N-1:0][LAT_W-1:0] waitLat,
  input logic [GRP_N-1:0]            resched
);
  localparam logic [LAT_W:0] MAXX = {1'b0, {LAT_W{1'b1}}};

  logic             armQ;
  logic [OPL_W-1:0] lat0Q;
  logic [LAT_W:0]   floorRaw;
  logic [LAT_W-1:0] floorT;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armQ  <= 1'b0;
      lat0Q <= '0;
    end else begin
      armQ  <= grpValid & instValid[0] & instValid[1] & dstEn[0] & (srcA[1] == dst[0]);
      lat0Q <= opLat[0];
    end
  end

  assign floorRaw = {1'b0, waitLat[0]} + (LAT_W + 1)'(lat0Q);
  assign floorT   = (floorRaw > MAXX) ? MAXX[LAT_W-1:0] : floorRaw[LAT_W-1:0];

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(!grpValid) |-> outValid == '0);

  p_slot_mask_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(grpValid) |-> outValid == $past(instValid));

  p_bypass_floor_r5: assert property (@(posedge clk) disable iff (!rstN)
    armQ |-> waitLat[1] >= floorT);

  for (genvar s = 0; s < GRP_N; s++) begin : g_chk
    p_dead_slot_r10: assert property (@(posedge clk) disable iff (!rstN)
      !outValid[s] |-> (waitLat[s] == '0 && !resched[s]));
    p_resched_live_r8: assert property (@(posedge clk) disable iff (!rstN)
      resched[s] |-> outValid[s]);
  end
endmodule

bind prsched_top prsched_chk #(
  .NUM_PREGS(NUM_PREGS),
  .LAT_W    (LAT_W),
  .OPL_W    (OPL_W)
) u_chk (.*);

// File: tb/sim_prsched_top.sv
module sim_prsched_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic grpValid = 1'b0;
  logic [3:0] instValid = '0, dstEn = '0;
  logic [3:0][4:0] srcA = '0, srcB = '0, dst = '0;
  logic [3:0][2:0] opLat = '0;
  logic [3:0] outValid, resched;
  logic [3:0][3:0] waitLat;

  prsched_top u0 (.*);

  always #2 clk = ~clk;

  typedef struct {
    logic [3:0]      vld;
    logic [3:0][3:0] lat;
    logic [3:0]      rs;
    string           tag;
  } exp_t;

  exp_t q[$];
  int nChk = 0, nFail = 0;
  int mt[32];
  bit sv[4], se[4];
  int sa[4], sb[4], sd[4], sl[4];

  task automatic check(string tag, int act, int expv, string what);
    nChk++;
    if (act != expv) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic slot(int i, bit v, bit en, int a, int b, int d, int l);
    sv[i] = v; se[i] = en; sa[i] = a; sb[i] = b; sd[i] = d; sl[i] = l;
  endtask

  task automatic clearSlots();
    for (int i = 0; i < 4; i++) slot(i, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic decay();
    for (int k = 0; k < 32; k++) mt[k] = (mt[k] > 0) ? mt[k] - 1 : 0;
  endtask

  // drive one group; predict results from the requirements and queue them
  task automatic fire(string tag);
    int dT[4]; int iss; int a; int b; int s; bit ov; exp_t e;
    @(negedge clk);
    grpValid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      instValid[i] = sv[i]; dstEn[i] = se[i];
      srcA[i] = 5'(sa[i]); srcB[i] = 5'(sb[i]); dst[i] = 5'(sd[i]); opLat[i] = 3'(sl[i]);
    end
    e.tag = tag;
    for (int i = 0; i < 4; i++) begin
      a = mt[sa[i]]; b = mt[sb[i]];
      for (int j = 0; j < i; j++) begin
        if (sv[j] && se[j] && sd[j] == sa[i]) a = dT[j];
        if (sv[j] && se[j] && sd[j] == sb[i]) b = dT[j];
      end
      iss = (a > b) ? a : b;
      s = iss + sl[i];
      ov = s > 15;
      dT[i] = ov ? 15 : s;
      e.vld[i] = sv[i];
      e.lat[i] = sv[i] ? 4'(iss) : 4'd0;
      e.rs[i]  = sv[i] & ov;
    end
    if (e.vld != 0) q.push_back(e);
    decay();
    for (int j = 0; j < 4; j++)
      if (sv[j] && se[j]) mt[sd[j]] = (dT[j] > 0) ? dT[j] - 1 : 0;
  endtask

  // dropped group: slots carry writes but grpValid stays low
  task automatic ghost();
    @(negedge clk);
    grpValid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      instValid[i] = sv[i]; dstEn[i] = se[i];
      srcA[i] = 5'(sa[i]); srcB[i] = 5'(sb[i]); dst[i] = 5'(sd[i]); opLat[i] = 3'(sl[i]);
    end
    decay();
  endtask

  task automatic idle(int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      grpValid = 1'b0; instValid = '0; dstEn = '0;
      decay();
    end
  endtask

  // monitor: results come out one edge after the group
  initial begin
    exp_t e;
    forever begin
      @(posedge clk); #1;
      if (rstN && outValid != 0) begin
        if (q.size() == 0) begin
          check("R10", int'(outValid), 0, "unexpected outValid");
        end else begin
          e = q.pop_front();
          check(e.tag, int'(outValid), int'(e.vld), "outValid mask");
          for (int i = 0; i < 4; i++) if (e.vld[i]) begin
            check(e.tag, int'(waitLat[i]), int'(e.lat[i]), $sformatf("waitLat slot%0d", i));
            check(e.tag, int'(resched[i]), int'(e.rs[i]), $sformatf("resched slot%0d", i));
          end
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        nFail++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] lf;
    for (int k = 0; k < 32; k++) mt[k] = 0;
    clearSlots();
    repeat (3) @(negedge clk);
    check("R1", int'(outValid), 0, "outValid in reset");
    check("R1", int'(waitLat), 0, "waitLat in reset");
    check("R1", int'(resched), 0, "resched in reset");
    rstN = 1'b1;
    idle(2);

    // R1: untouched registers read as ready
    slot(0, 1, 0, 3, 4, 0, 0); slot(1, 1, 0, 20, 31, 0, 0);
    fire("R1"); clearSlots();

    // R3 / R4: producer then consumers at increasing distance
    slot(0, 1, 1, 0, 0, 1, 5);
    fire("R3"); clearSlots();
    slot(0, 1, 0, 1, 0, 0, 0);
    fire("R3");
    fire("R4");
    idle(2);
    fire("R4");
    idle(4);
    fire("R4"); clearSlots();

    // R2: max of two sources in either operand position
    slot(0, 1, 1, 0, 0, 2, 6); slot(1, 1, 1, 0, 0, 3, 2);
    fire("R2"); clearSlots();
    slot(0, 1, 0, 2, 3, 0, 0); slot(1, 1, 0, 3, 2, 0, 0); slot(2, 1, 0, 3, 3, 0, 0);
    fire("R2"); clearSlots();

    // R5: chain through the group
    idle(8);
    slot(0, 1, 1, 0, 0, 5, 5); slot(1, 1, 1, 5, 0, 6, 4);
    slot(2, 1, 0, 0, 6, 0, 0); slot(3, 1, 1, 6, 5, 8, 1);
    fire("R5"); clearSlots();
    slot(0, 1, 0, 8, 5, 0, 0);
    fire("R5"); clearSlots();

    // R6 / R7: two writers of one register
    idle(16);
    slot(0, 1, 1, 0, 0, 7, 2); slot(1, 1, 1, 0, 0, 7, 6);
    slot(2, 1, 0, 7, 0, 0, 0); slot(3, 1, 1, 0, 0, 11, 3);
    fire("R6"); clearSlots();
    slot(0, 1, 0, 7, 0, 0, 0);
    fire("R7"); clearSlots();
    slot(0, 1, 1, 0, 0, 12, 6); slot(1, 1, 1, 0, 0, 12, 1);
    fire("R7"); clearSlots();
    slot(0, 1, 0, 0, 12, 0, 0);
    fire("R7"); clearSlots();

    // R8: saturation and reschedule
    idle(16);
    slot(0, 1, 1, 0, 0, 13, 7); slot(1, 1, 1, 13, 0, 14, 7);
    slot(2, 1, 1, 14, 14, 15, 7); slot(3, 1, 1, 15, 0, 16, 7);
    fire("R8"); clearSlots();
    slot(0, 1, 0, 15, 0, 0, 0); slot(1, 1, 1, 16, 0, 17, 7);
    fire("R8"); clearSlots();

    // R9: ghost writes must not land in the table
    idle(16);
    slot(0, 0, 1, 0, 0, 9, 7); slot(1, 1, 0, 0, 0, 0, 0); slot(3, 0, 1, 0, 0, 21, 6);
    fire("R9"); clearSlots();
    slot(0, 1, 1, 0, 0, 10, 7); slot(2, 1, 1, 0, 0, 22, 5);
    ghost(); clearSlots();
    slot(0, 1, 0, 9, 10, 0, 0); slot(1, 1, 0, 21, 22, 0, 0);
    fire("R9"); clearSlots();

    // R10: sparse masks
    slot(1, 1, 1, 0, 0, 23, 3); slot(3, 1, 0, 23, 0, 0, 0);
    fire("R10"); clearSlots();
    slot(2, 1, 0, 23, 23, 0, 0);
    fire("R10"); clearSlots();

    // R2: back-to-back pseudo-random groups
    lf = 16'hACE1;
    for (int g = 0; g < 60; g++) begin
      for (int i = 0; i < 4; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        slot(i, lf[0] | lf[1], lf[2], int'(lf[5:3]), int'(lf[8:6]), int'(lf[11:9]), int'(lf[14:12]));
      end
      fire("R2");
      if (lf[3]) idle(1);
    end
    clearSlots();
    idle(4);
    check("R10", q.size(), 0, "pending results");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule